// File: doc/BRIEF.md
# Card Controller Interrupt Status and Mask Unit

This unit collects the condition signals of a card-interface controller into one 32-bit status word and turns them into a single interrupt line. Ready and busy conditions from the command and data engines, and the two SDIO slot requests, are shown live. Response and data errors arrive as one-cycle pulses. They are captured into sticky flags that hold until a software reset or the start of a new command.

Software controls a 32-bit interrupt mask through a small register port. A write to the enable register sets the mask bits where the data has ones. A write to the disable register clears the mask bits where the data has ones. The mask can be read back. The interrupt line is a registered OR over the status word ANDed with the mask.

Top module: `irq_status_unit`

## Requirements
- R1: Status bits follow the live inputs without delay: bit 0 command ready, bit 1 receive ready, bit 2 transmit ready, bit 3 block ended, bit 4 transfer in progress, bit 5 not busy (`live_i[5:0]` maps to the same positions). Bits 8 and 9 follow `sdio_irq_i[0]` (slot A) and `sdio_irq_i[1]` (slot B).
- R2: A pulse on `rsp_err_i` is shown in the status word from the next cycle on and stays there. The bits map as `rsp_err_i[0..4]` to status bits 16..20, meaning index, direction, CRC, end bit and timeout.
- R3: A pulse on `dat_err_i` is captured as a sticky flag in the same way. The mapping is `dat_err_i[0]` data CRC to bit 21, `[1]` data timeout to bit 22, `[2]` overrun to bit 30 and `[3]` underrun to bit 31.
- R4: A write to address 1 (enable) sets every valid mask bit where `wr_data_i` is 1. All other mask bits keep their value.
- R5: A write to address 2 (disable) clears every mask bit where `wr_data_i` is 1. Writing all ones clears the whole mask.
- R6: Reading address 0 returns the status word and reading address 3 returns the mask. Bit positions that are not listed in R1 to R3 read as zero in both and can never be set in the mask. Writes to addresses 0 and 3 change nothing.
- R7: `irq_o` equals the OR of (status AND mask) as it stood before the previous rising clock edge. It is registered, so it follows a change by exactly one cycle.
- R8: `cmd_start_i` clears all sticky error flags. If an error pulse arrives in the same cycle, that error is set anyway.
- R9: `soft_rst_i` clears the mask and all sticky error flags. It takes priority over an error pulse or an enable write in the same cycle.
- R10: After `rst_ni` the mask and the sticky errors are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Software reset command |
| cmd_start_i | input | 1 | A new command starts; clears sticky errors |
| live_i | input | 6 | Live ready/busy conditions, status bits 5..0 |
| sdio_irq_i | input | 2 | SDIO slot requests, status bits 9..8 |
| rsp_err_i | input | 5 | Response error pulses |
| dat_err_i | input | 4 | Data error pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 1 enable, 2 disable |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address: 0 status, 3 mask |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Two cases can fall in the same cycle: an error pulse arriving together with the start-of-command clear, and a software reset arriving together with an error pulse and an enable write. Directed steps drive each pair on one edge. The random phase also makes them collide often, through independent per-cycle choices. A bench model applies the stated priorities: an error beats the command clear, and the software reset beats everything. The status word, the mask and the interrupt line are compared with that model after every edge.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int DW       = 32;
  localparam int AW       = 2;
  localparam int LIVE_N   = 6;
  localparam int SLOT_N   = 2;
  localparam int RSP_N    = 5;
  localparam int DAT_N    = 4;
  localparam int SLOT_LSB = 8;
  localparam int RSP_LSB  = 16;
  localparam int DCRC_BIT = 21;
  localparam int DTO_BIT  = 22;
  localparam int OVR_BIT  = 30;
  localparam int UND_BIT  = 31;

  localparam logic [DW-1:0] ERR_BITS   = 32'hC07F_0000;
  localparam logic [DW-1:0] VALID_BITS = 32'hC07F_033F;

  typedef enum logic [AW-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENA    = 2'd1,
    SEL_DIS    = 2'd2,
    SEL_MASK   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_word.sv
module irq_status_word
  import irq_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cmd_start_i,
  input  logic [LIVE_N-1:0] live_i,
  input  logic [SLOT_N-1:0] sdio_irq_i,
  input  logic [RSP_N-1:0]  rsp_err_i,
  input  logic [DAT_N-1:0]  dat_err_i,
  output logic [DW-1:0]     status_o
);
  logic [RSP_N-1:0] rsp_q;
  logic [DAT_N-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= '0;
      dat_q <= '0;
    end else if (soft_rst_i) begin
      rsp_q <= '0;
      dat_q <= '0;
    end else begin
      // new error wins over command-start clear
      rsp_q <= (cmd_start_i ? '0 : rsp_q) | rsp_err_i;
      dat_q <= (cmd_start_i ? '0 : dat_q) | dat_err_i;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[LIVE_N-1:0]                = live_i;
    status_o[SLOT_LSB +: SLOT_N]        = sdio_irq_i;
    status_o[RSP_LSB +: RSP_N]          = rsp_q;
    status_o[DCRC_BIT]                  = dat_q[0];
    status_o[DTO_BIT]                   = dat_q[1];
    status_o[OVR_BIT]                   = dat_q[2];
    status_o[UND_BIT]                   = dat_q[3];
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_status_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_q <= '0;
    else if (soft_rst_i) mask_q <= '0;
    else                 mask_q <= ((mask_q & ~clr_i) | set_i) & VALID_BITS;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_status_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mask_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cmd_start_i,
  input  logic [LIVE_N-1:0] live_i,
  input  logic [SLOT_N-1:0] sdio_irq_i,
  input  logic [RSP_N-1:0]  rsp_err_i,
  input  logic [DAT_N-1:0]  dat_err_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              irq_o
);
  logic [DW-1:0] status_w;
  logic [DW-1:0] mask_w;
  logic [DW-1:0] set_w;
  logic [DW-1:0] clr_w;

  assign set_w = (wr_en_i && wr_addr_i == SEL_ENA) ? wr_data_i : '0;
  assign clr_w = (wr_en_i && wr_addr_i == SEL_DIS) ? wr_data_i : '0;

  irq_status_word u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .cmd_start_i (cmd_start_i),
    .live_i      (live_i),
    .sdio_irq_i  (sdio_irq_i),
    .rsp_err_i   (rsp_err_i),
    .dat_err_i   (dat_err_i),
    .status_o    (status_w)
  );

  irq_mask_reg u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .set_i      (set_w),
    .clr_i      (clr_w),
    .mask_o     (mask_w)
  );

  irq_line u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_w),
    .mask_i   (mask_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (rd_addr_i)
      SEL_STATUS: rd_data_o = status_w;
      SEL_MASK:   rd_data_o = mask_w;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic             cmd_start_i,
  input logic [RSP_N-1:0] rsp_err_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [DW-1:0]    mask_i,
  input logic [DW-1:0]    status_i,
  input logic             irq_o
);
  // R4
  enable_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_ENA && !soft_rst_i) |=>
      ((mask_i & $past(wr_data_i) & VALID_BITS) == ($past(wr_data_i) & VALID_BITS)));

  // R5
  disable_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_DIS) |=> ((mask_i & $past(wr_data_i)) == '0));

  // R6
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_i & ~VALID_BITS) == '0) && ((status_i & ~VALID_BITS) == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(status_i) & $past(mask_i))));

  // R2
  rsp_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_err_i != '0 && !soft_rst_i) |=>
      ((status_i[RSP_LSB +: RSP_N] & $past(rsp_err_i)) == $past(rsp_err_i)));

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_start_i && !soft_rst_i) |=>
      ((status_i & $past(status_i) & ERR_BITS) == ($past(status_i) & ERR_BITS)));

  // R9
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (mask_i == '0) && ((status_i & ERR_BITS) == '0));
endmodule

bind irq_status_unit irq_status_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .cmd_start_i (cmd_start_i),
  .rsp_err_i   (rsp_err_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .mask_i      (mask_w),
  .status_i    (status_w),
  .irq_o       (irq_o)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  localparam int CLK_P = 10;
  localparam logic [31:0] VALID = 32'hC07F_033F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        cmd_start_i = 1'b0;
  logic [5:0]  live_i = '0;
  logic [1:0]  sdio_irq_i = '0;
  logic [4:0]  rsp_err_i = '0;
  logic [3:0]  dat_err_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  logic [4:0]  rsp_m = '0;
  logic [3:0]  dat_m = '0;
  logic [31:0] mask_m = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  irq_status_unit u0 (.*);

  function automatic logic [31:0] f_status(logic [5:0] lv, logic [1:0] sd,
                                           logic [4:0] rs, logic [3:0] dt);
    logic [31:0] s = '0;
    s[5:0] = lv; s[9:8] = sd; s[20:16] = rs;
    s[21] = dt[0]; s[22] = dt[1]; s[30] = dt[2]; s[31] = dt[3];
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic readback(string tag);
    rd_addr_i = 2'd3; #1;
    chk({tag, " mask"}, rd_data_o, mask_m);
    rd_addr_i = 2'd0; #1;
    chk({tag, " status"}, rd_data_o, f_status(live_i, sdio_irq_i, rsp_m, dat_m));
    rd_addr_i = 2'd1; #1;
    chk({tag, " R6 unmapped read"}, rd_data_o, 32'h0);
  endtask

  // inputs are set; model one edge, then compare
  task automatic step(string tag);
    logic exp_irq;
    exp_irq = |(f_status(live_i, sdio_irq_i, rsp_m, dat_m) & mask_m);
    if (soft_rst_i) begin
      rsp_m = '0; dat_m = '0; mask_m = '0;
    end else begin
      rsp_m = (cmd_start_i ? 5'd0 : rsp_m) | rsp_err_i;
      dat_m = (cmd_start_i ? 4'd0 : dat_m) | dat_err_i;
      if (wr_en_i && wr_addr_i == 2'd1) mask_m = (mask_m | wr_data_i) & VALID;
      if (wr_en_i && wr_addr_i == 2'd2) mask_m = mask_m & ~wr_data_i;
    end
    @(posedge clk_i); #1;
    chk({tag, " R7 irq"}, {31'd0, irq_o}, {31'd0, exp_irq});
    soft_rst_i = 0; cmd_start_i = 0; rsp_err_i = '0; dat_err_i = '0;
    wr_en_i = 0; wr_addr_i = '0; wr_data_i = '0;
    readback(tag);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
  endtask

  initial begin
    #(CLK_P*150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    live_i = 6'h2A; sdio_irq_i = 2'b01;
    #(CLK_P*3);
    chk("R10 irq in reset", {31'd0, irq_o}, 32'd0);
    readback("R10 reset");
    @(negedge clk_i); rst_ni = 1; #1;
    readback("R10 after release");

    // R1 live bits
    live_i = 6'h15; sdio_irq_i = 2'b10; #1;
    readback("R1 live");

    // R4 / R6: enable all ones only sets valid bits
    wr(2'd1, 32'hFFFF_FFFF); step("R4 R6 enable all");
    // R6 writes to status and mask addresses ignored
    wr(2'd0, 32'h0); step("R6 write addr0");
    wr(2'd3, 32'h0); step("R6 write addr3");
    // R5 disable all ones
    wr(2'd2, 32'hFFFF_FFFF); step("R5 disable all");
    chk("R5 mask empty", mask_m, 32'h0);

    // R2 response error, enabled at bit 18 (CRC)
    live_i = '0; sdio_irq_i = '0;
    wr(2'd1, 32'h0004_0000); step("R4 enable bit18");
    step("R7 idle");
    rsp_err_i = 5'b00100; step("R2 rsp crc pulse");
    step("R2 rsp sticky hold");
    // R3 data errors
    dat_err_i = 4'b1001; step("R3 dat crc+underrun");
    step("R3 dat sticky hold");
    // R8 clear with same-cycle error
    cmd_start_i = 1; rsp_err_i = 5'b10000; step("R8 start with error");
    cmd_start_i = 1; step("R8 start clears");
    // R9 soft reset beats error and enable
    wr(2'd1, 32'h0000_0001); step("R4 enable bit0");
    live_i = 6'h01; step("R7 live irq");
    soft_rst_i = 1; dat_err_i = 4'b0100; wr(2'd1, 32'hFFFF_FFFF); step("R9 soft reset priority");
    step("R9 after soft");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      live_i = 6'($urandom);
      sdio_irq_i = 2'($urandom);
      rsp_err_i = ($urandom % 6 == 0) ? 5'(1 << ($urandom % 5)) : 5'd0;
      dat_err_i = ($urandom % 6 == 0) ? 4'(1 << ($urandom % 4)) : 4'd0;
      cmd_start_i = ($urandom % 10 == 0);
      soft_rst_i = ($urandom % 60 == 0);
      if ($urandom % 3 == 0) wr(2'($urandom), $urandom);
      step("R1 R2 R3 R4 R5 R8 R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule